// File: doc/BRIEF.md
# Doubled Frame-Buffer Scan-Out with Line Cache

This block produces a complete video raster: horizontal and vertical counters, active-low sync pulses, a data-enable strobe and a 12-bit colour word. A small byte-per-pixel frame buffer (256×192 by default) is shown in the middle of a 640×480 raster. Each stored pixel is drawn as a 2×2 block, so the visible image is a centred 512×384 window. Outside that window data-enable stays low and the colour is black.

Frame-buffer memory is read ahead of display into a bank of 32-bit registers that holds one full source row. The fetch for a row runs in the horizontal blanking just before the first of the two output lines that show that row. The second output line reuses the same registers. While the window is drawn, the current pixel is taken from those registers through combinational selection. The memory's read latency therefore never shifts the picture.

Each 3-3-2 pixel is widened to three 4-bit channels by bit replication. The frame-buffer page to display comes from an input and is captured once per frame, when vertical blanking starts.

Top module: `fb_scanout`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the raster position is column 0, line 0. At that position data-enable is low, both syncs are high, the colour is zero and no memory read is requested. The displayed page resets to 0.
- R2: The position advances by one column per clock. After the last column (H_ACT+H_FP+H_SYNC+H_BP−1) it returns to column 0 and the line advances. After the last line (V_ACT+V_FP+V_SYNC+V_BP−1) it returns to line 0.
- R3: hsync_n is low exactly for columns H_ACT+H_FP through H_ACT+H_FP+H_SYNC−1. vsync_n is low exactly for lines V_ACT+V_FP through V_ACT+V_FP+V_SYNC−1. Both depend only on the current position, so vsync_n changes only at column 0.
- R4: de is high exactly when the column lies in [WIN_X0, WIN_X0+2·FB_W) and the line lies in [WIN_Y0, WIN_Y0+2·FB_H). Since the window sits inside the active area, de is never high during a sync pulse.
- R5: Whenever de is low, rgb is zero.
- R6: Inside the window, output (c, l) shows source pixel x = (c−WIN_X0)/2 of row y = (l−WIN_Y0)/2. Pixel x is byte x mod 4 of word x/4, and byte 0 occupies bits 7:0.
- R7: A pixel byte p is shown as rgb = {R,G,B}, with R = {p[7:5],p[7]}, G = {p[4:2],p[4]} and B = {p[1:0],p[1:0]}. R is in bits 11:8.
- R8: rd_en is high on line l, at columns H_ACT through H_ACT+FB_W/4−1, exactly when line l+1 is inside the window at an even offset from WIN_Y0. At column H_ACT+i the request carries rd_addr = {page, row, i}, where row = (l+1−WIN_Y0)/2. There are no requests at any other time.
- R9: Read data is taken from rd_data exactly RD_LAT cycles after its request. The picture is correct for any RD_LAT for which the fetch fits in horizontal blanking.
- R10: page_sel is sampled only at column 0 of line V_ACT. A change at any other time has no effect on fetch addresses or displayed pixels until that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_sel | input | 1 | Frame-buffer page requested for the next frame |
| rd_en | output | 1 | Frame-buffer read request |
| rd_addr | output | AW | Word address {page, row, word} |
| rd_data | input | 32 | Read word, valid RD_LAT cycles after the request |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high inside the doubled window |
| rgb | output | 12 | Expanded colour {R[3:0],G[3:0],B[3:0]} |

## Verification
The bench builds the block with a 16×4 frame buffer in a 70×17 raster, with the window at column 8, line 2 and a read latency of two cycles. One frame is then about 1,200 clocks, so several whole frames, two page swaps made mid-frame, a reset in mid-run and a refetch pipeline deeper than one stage all fit in a short run. Every column, line, sync edge, window edge and fetch slot is compared against an independent model of the raster.

// File: rtl/fbscan_pkg.sv
`timescale 1ns/1ps
package fbscan_pkg;
  localparam int PIX_W        = 8;
  localparam int WORD_W       = 32;
  localparam int PIX_PER_WORD = WORD_W / PIX_W;
  localparam int RGB_W        = 12;

  // 3-3-2 byte to three 4-bit channels, low bits filled from the top bits
  function automatic logic [RGB_W-1:0] expand_332(input logic [PIX_W-1:0] p);
    return {p[7:5], p[7], p[4:2], p[4], p[1:0], p[1:0]};
  endfunction

  // byte lane 0 sits in the least significant byte of a word
  function automatic logic [PIX_W-1:0] pick_pixel(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] lane);
    return w[lane*PIX_W +: PIX_W];
  endfunction
endpackage

// File: rtl/fbscan_timing.sv
`timescale 1ns/1ps
module fbscan_timing #(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int WIN_X0 = 64,
  parameter int WIN_W  = 512,
  parameter int WIN_Y0 = 48,
  parameter int WIN_H  = 384,
  parameter int HW     = 10,
  parameter int VW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          in_win,
  output logic          line_start,
  output logic          vblank_start
);
  localparam logic [HW-1:0] H_LAST  = HW'(H_ACT + H_FP + H_SYNC + H_BP - 1);
  localparam logic [VW-1:0] V_LAST  = VW'(V_ACT + V_FP + V_SYNC + V_BP - 1);
  localparam logic [HW-1:0] HS_B    = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_E    = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_B    = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_E    = VW'(V_ACT + V_FP + V_SYNC);
  localparam logic [HW-1:0] WX_B    = HW'(WIN_X0);
  localparam logic [HW-1:0] WX_E    = HW'(WIN_X0 + WIN_W);
  localparam logic [VW-1:0] WY_B    = VW'(WIN_Y0);
  localparam logic [VW-1:0] WY_E    = VW'(WIN_Y0 + WIN_H);
  localparam logic [VW-1:0] V_BLANK = VW'(V_ACT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hcnt == H_LAST) begin
      hcnt <= '0;
      vcnt <= (vcnt == V_LAST) ? '0 : vcnt + VW'(1);
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  always_comb begin
    hsync_n      = !((hcnt >= HS_B) && (hcnt < HS_E));
    vsync_n      = !((vcnt >= VS_B) && (vcnt < VS_E));
    in_win       = (hcnt >= WX_B) && (hcnt < WX_E) && (vcnt >= WY_B) && (vcnt < WY_E);
    line_start   = (hcnt == '0);
    vblank_start = line_start && (vcnt == V_BLANK);
  end
endmodule

// File: rtl/fbscan_fill.sv
`timescale 1ns/1ps
module fbscan_fill #(
  parameter int H_ACT  = 640,
  parameter int WIN_Y0 = 48,
  parameter int WIN_H  = 384,
  parameter int WORDS  = 64,
  parameter int RD_LAT = 1,
  parameter int HW     = 10,
  parameter int VW     = 10,
  parameter int RW     = 8,
  parameter int WDW    = 6,
  parameter int AW     = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HW-1:0]  hcnt,
  input  logic [VW-1:0]  vcnt,
  input  logic           page,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  output logic           cache_we,
  output logic [WDW-1:0] cache_idx
);
  localparam logic [VW-1:0] WY_B = VW'(WIN_Y0);
  localparam logic [VW-1:0] WY_E = VW'(WIN_Y0 + WIN_H);
  localparam logic [HW-1:0] F_B  = HW'(H_ACT);
  localparam logic [HW-1:0] F_E  = HW'(H_ACT + WORDS);

  logic [VW-1:0]  nxt_line, rel;
  logic [RW-1:0]  row;
  logic [WDW-1:0] word;
  logic           fill_line, fill_col;

  always_comb begin
    nxt_line  = vcnt + VW'(1);
    rel       = nxt_line - WY_B;
    fill_line = (nxt_line >= WY_B) && (nxt_line < WY_E) && !rel[0];
    fill_col  = (hcnt >= F_B) && (hcnt < F_E);
    row       = RW'(rel >> 1);
    word      = WDW'(hcnt - F_B);
    rd_en     = fill_line && fill_col;
    rd_addr   = {page, row, word};
  end

  // request tags travel alongside the memory latency
  logic [RD_LAT-1:0] vld_q;
  logic [WDW-1:0]    idx_q [RD_LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < RD_LAT; i++) idx_q[i] <= '0;
    end else begin
      for (int i = RD_LAT - 1; i > 0; i--) begin
        vld_q[i] <= vld_q[i-1];
        idx_q[i] <= idx_q[i-1];
      end
      vld_q[0] <= rd_en;
      idx_q[0] <= word;
    end
  end

  assign cache_we  = vld_q[RD_LAT-1];
  assign cache_idx = idx_q[RD_LAT-1];
endmodule

// File: rtl/fbscan_cache.sv
`timescale 1ns/1ps
module fbscan_cache
  import fbscan_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int WDW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WDW-1:0]    widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WDW-1:0]    ridx,
  input  logic [1:0]        rlane,
  output logic [PIX_W-1:0]  pixel
);
  logic [WORD_W-1:0] line_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                           line_q[g] <= '0;
      else if (we && (widx == WDW'(g)))     line_q[g] <= wdata;
    end
  end

  assign pixel = pick_pixel(line_q[ridx], rlane);
endmodule

// File: rtl/fb_scanout.sv
`timescale 1ns/1ps
module fb_scanout
  import fbscan_pkg::*;
#(
  parameter int FB_W   = 256,
  parameter int FB_H   = 192,
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int WIN_X0 = 64,
  parameter int WIN_Y0 = 48,
  parameter int RD_LAT = 1,
  localparam int AW    = 1 + $clog2(FB_H) + $clog2(FB_W / 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          page_sel,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          de,
  output logic [11:0]   rgb
);
  localparam int WIN_W = 2 * FB_W;
  localparam int WIN_H = 2 * FB_H;
  localparam int WORDS = FB_W / PIX_PER_WORD;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int RW    = $clog2(FB_H);
  localparam int WDW   = $clog2(WORDS);
  localparam int XW    = $clog2(FB_W);
  localparam logic [HW-1:0] WX_B = HW'(WIN_X0);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          in_win;
  // events brought out for the bound checker
  logic          line_start, vblank_start, cache_wr, scan_page;
  logic [WDW-1:0] cache_idx;

  fbscan_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .WIN_X0(WIN_X0), .WIN_W(WIN_W), .WIN_Y0(WIN_Y0), .WIN_H(WIN_H),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .in_win(in_win),
    .line_start(line_start), .vblank_start(vblank_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            scan_page <= 1'b0;
    else if (vblank_start) scan_page <= page_sel;
  end

  fbscan_fill #(
    .H_ACT(H_ACT), .WIN_Y0(WIN_Y0), .WIN_H(WIN_H), .WORDS(WORDS),
    .RD_LAT(RD_LAT), .HW(HW), .VW(VW), .RW(RW), .WDW(WDW), .AW(AW)
  ) u_fill (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .page(scan_page),
    .rd_en(rd_en), .rd_addr(rd_addr), .cache_we(cache_wr), .cache_idx(cache_idx)
  );

  logic [XW-1:0]    src_x;
  logic [PIX_W-1:0] pixel;

  assign src_x = XW'((hcnt - WX_B) >> 1);

  fbscan_cache #(.WORDS(WORDS), .WDW(WDW)) u_cache (
    .clk(clk), .rst_n(rst_n), .we(cache_wr), .widx(cache_idx), .wdata(rd_data),
    .ridx(src_x[XW-1:2]), .rlane(src_x[1:0]), .pixel(pixel)
  );

  assign de  = in_win;
  assign rgb = in_win ? expand_332(pixel) : '0;
endmodule

// File: rtl/fb_scanout_chk.sv
`timescale 1ns/1ps
module fb_scanout_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        de,
  input logic        hsync_n,
  input logic        vsync_n,
  input logic [11:0] rgb,
  input logic        rd_en,
  input logic        cache_wr,
  input logic        line_start,
  input logic        vblank_start,
  input logic        scan_page
);
  p_blank_black_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (rgb == 12'h000));

  p_de_off_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync_n && vsync_n));

  p_fetch_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !de);

  p_fill_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cache_wr |-> !de);

  p_page_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_start |=> $stable(scan_page));

  p_vsync_line_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_n != $past(vsync_n)) |-> line_start);
endmodule

bind fb_scanout fb_scanout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .de(de), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .rgb(rgb), .rd_en(rd_en), .cache_wr(cache_wr), .line_start(line_start),
  .vblank_start(vblank_start), .scan_page(scan_page)
);

// File: tb/fb_scanout_tb_top.sv
`timescale 1ns/1ps
module fb_scanout_tb_top;
  localparam int FB_W = 16, FB_H = 4;
  localparam int H_ACT = 48, H_FP = 4, H_SYNC = 6, H_BP = 12;
  localparam int V_ACT = 12, V_FP = 1, V_SYNC = 2, V_BP = 2;
  localparam int WIN_X0 = 8, WIN_Y0 = 2, RD_LAT = 2;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int WORDS = FB_W / 4;
  localparam int AW = 5;
  localparam int WD_CYCLES = 150000;

  // table: {column, line, hsync_n, vsync_n, de}, in raster order (R2 R3 R4)
  localparam logic [18:0] VEC [15] = '{
    {8'd0,  8'd0,  3'b110}, {8'd51, 8'd0,  3'b110}, {8'd52, 8'd0,  3'b010},
    {8'd57, 8'd0,  3'b010}, {8'd58, 8'd0,  3'b110}, {8'd7,  8'd2,  3'b110},
    {8'd8,  8'd2,  3'b111}, {8'd39, 8'd2,  3'b111}, {8'd40, 8'd2,  3'b110},
    {8'd39, 8'd9,  3'b111}, {8'd8,  8'd10, 3'b110}, {8'd0,  8'd12, 3'b110},
    {8'd0,  8'd13, 3'b100}, {8'd69, 8'd14, 3'b100}, {8'd0,  8'd15, 3'b110}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic page_sel = 1'b0;
  logic rd_en, hsync_n, vsync_n, de;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data;
  logic [11:0] rgb;
  logic [31:0] mem_d0 = '0, mem_d1 = '0;

  int n_chk = 0, n_fail = 0;
  int h = 0, v = 0;
  bit page_m = 1'b0;

  always #2.5 clk = ~clk;

  fb_scanout #(
    .FB_W(FB_W), .FB_H(FB_H), .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .WIN_X0(WIN_X0), .WIN_Y0(WIN_Y0), .RD_LAT(RD_LAT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .rgb(rgb)
  );

  function automatic int pix(input int pg, input int row, input int x);
    return (x * 37 + row * 11 + pg * 101 + 5) % 256;
  endfunction

  function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
    int pg = int'(a[4]);
    int row = int'(a[3:2]);
    int base = 4 * int'(a[1:0]);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++) w = w | (32'(pix(pg, row, base + b)) << (8 * b));
    return w;
  endfunction

  // two-stage read pipe: data appears RD_LAT cycles after the address
  always @(posedge clk) begin
    mem_d0 <= mem_word(rd_addr);
    mem_d1 <= mem_d0;
  end
  assign rd_data = mem_d1;

  function automatic int expect_rgb(input int p);
    int r3 = p / 32, g3 = (p / 4) % 8, b2 = p % 4;
    return ((r3 * 2 + r3 / 4) * 256) + ((g3 * 2 + g3 / 4) * 16) + b2 * 5;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at col %0d line %0d: actual=%0h expected=%0h", tag, h, v, act, exp);
    end
  endtask

  task automatic step();
    if (h == 0 && v == V_ACT) page_m = page_sel;
    @(negedge clk);
    if (h == H_TOT - 1) begin
      h = 0;
      v = (v == V_TOT - 1) ? 0 : v + 1;
    end else begin
      h++;
    end
  endtask

  task automatic check_idle(input string tag);
    chk(de == 1'b0, {tag, " de"}, int'(de), 0);
    chk(hsync_n == 1'b1, {tag, " hsync"}, int'(hsync_n), 1);
    chk(vsync_n == 1'b1, {tag, " vsync"}, int'(vsync_n), 1);
    chk(rgb == 12'h000, {tag, " rgb"}, int'(rgb), 0);
    chk(rd_en == 1'b0, {tag, " rd_en"}, int'(rd_en), 0);
  endtask

  task automatic check_model();
    bit e_hs = !(h >= H_ACT + H_FP && h < H_ACT + H_FP + H_SYNC);
    bit e_vs = !(v >= V_ACT + V_FP && v < V_ACT + V_FP + V_SYNC);
    bit e_de = (h >= WIN_X0 && h < WIN_X0 + 2 * FB_W && v >= WIN_Y0 && v < WIN_Y0 + 2 * FB_H);
    int nl = v + 1;
    bit e_rd = (nl >= WIN_Y0 && nl < WIN_Y0 + 2 * FB_H && ((nl - WIN_Y0) % 2 == 0) &&
                h >= H_ACT && h < H_ACT + WORDS);
    int e_rgb = e_de ? expect_rgb(pix(int'(page_m), (v - WIN_Y0) / 2, (h - WIN_X0) / 2)) : 0;
    chk(hsync_n == e_hs, "R2 R3 hsync", int'(hsync_n), int'(e_hs));
    chk(vsync_n == e_vs, "R2 R3 vsync", int'(vsync_n), int'(e_vs));
    chk(de == e_de, "R4 de", int'(de), int'(e_de));
    chk(int'(rgb) == e_rgb, e_de ? "R6 R7 R9 R10 pixel" : "R5 blank colour", int'(rgb), e_rgb);
    chk(rd_en == e_rd, "R8 rd_en", int'(rd_en), int'(e_rd));
    if (e_rd) begin
      int e_addr = int'(page_m) * 16 + ((nl - WIN_Y0) / 2) * 4 + (h - H_ACT);
      chk(int'(rd_addr) == e_addr, "R8 R10 rd_addr", int'(rd_addr), e_addr);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(WD_CYCLES * 5);
    n_fail++;
    $display("FAIL R2 watchdog expired: actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1: held in reset
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    h = 0; v = 0; page_m = 1'b0;
    check_idle("R1 after release");

    // frame 1: boundary table walk (R2 R3 R4)
    for (int i = 0; i < 15; i++) begin
      while (!(h == int'(VEC[i][18:11]) && v == int'(VEC[i][10:3]))) step();
      chk(hsync_n == VEC[i][2], "R3 table hsync", int'(hsync_n), int'(VEC[i][2]));
      chk(vsync_n == VEC[i][1], "R3 table vsync", int'(vsync_n), int'(VEC[i][1]));
      chk(de == VEC[i][0], "R4 table de", int'(de), int'(VEC[i][0]));
    end
    while (!(h == 0 && v == 0)) step();

    // frames 2..5 against the model, with page swaps made mid-frame (R10)
    for (int f = 0; f < 4; f++) begin
      do begin
        check_model();
        if (h == 0 && v == 5 && f == 0) page_sel = 1'b1;
        if (h == 0 && v == 11 && f == 2) page_sel = 1'b0;
        step();
      end while (!(h == 0 && v == 0));
    end

    // mid-run reset (R1), then one more frame
    while (!(h == 20 && v == 4)) begin
      check_model();
      step();
    end
    page_sel = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    h = 0; v = 0;
    check_idle("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    page_m = 1'b0;
    do begin
      check_model();
      step();
    end while (!(h == 0 && v == 0));
    // frame after reset shows the page latched at the last vblank (R10)
    do begin
      check_model();
      step();
    end while (!(h == 0 && v == 0));

    summary();
    $finish;
  end
endmodule